// File: doc/BRIEF.md
# External Interrupt Source Selector

This block picks which external-interrupt source a processor takes when an external interrupt is delivered. It tracks five sources:

- emergency signals, one pending bit for each sending CPU, held in a sender bitmap;
- an external call, with the address of the calling CPU;
- a clock-comparator condition;
- a CPU-timer condition;
- a service request, which comes from an outside queue as a level with a 32-bit parameter.

Each source has a subclass mask bit. A source can be picked only when it is pending and its mask bit is set. The picked source is the highest-priority one among those.

A higher-level arbiter watches the combinational `any_elig_o` flag and raises `deliver_i` for one cycle to take an interrupt. On that edge the block does four things:

- registers the interrupt code, the originating CPU address and the parameter of the winning source;
- retires the winner's pending state;
- for an emergency signal, clears only the lowest-numbered sender;
- for a service request, pops the outside queue.

A strobe that arrives while external interrupts are disabled, or while nothing is eligible, gives an error pulse instead.

Top module: `ext_irq_selector`

## Requirements
- R1: Priority from highest to lowest is emergency, external call, clock comparator, CPU timer, service. A source is eligible only when it is pending and its bit in `sc_mask_i` is set. The mask bits are: bit 0 emergency, bit 1 external call, bit 2 clock comparator, bit 3 CPU timer, bit 4 service.
- R2: An emergency delivery reports, as the CPU address, the lowest set index in the sender bitmap, and clears that bit only.
- R3: `pend_o[0]` (emergency pending) stays 1 while any sender bit remains set. It falls only when a delivery leaves the bitmap empty.
- R4: An external-call delivery reports the latched caller address and clears `pend_o[1]`. A new call while one is pending overwrites the address.
- R5: Clock-comparator and CPU-timer deliveries report CPU address 0 and parameter 0. Each clears only its own flag: `pend_o[2]` for the clock comparator, `pend_o[3]` for the CPU timer.
- R6: A service delivery reports CPU address 0 and, as the parameter, the value of `svc_param_i` in the strobe cycle. It raises `svc_pop_o` combinationally in that same cycle. Service pending is the `svc_avail_i` level and is not stored.
- R7: `any_elig_o` is combinational and is high exactly when at least one source is eligible, whatever the value of `ext_enable_i`.
- R8: A strobe with `ext_enable_i` low, or with no eligible source, makes `dlv_err_o` high for one cycle. In that case there is no valid delivery, no pop, and no pending state is cleared.
- R9: `dlv_valid_o` is high exactly in the cycle after an accepted strobe. The code is the source's parameterised encoding: emergency 0x1201, call 0x1202, clock comparator 0x1004, timer 0x1005, service 0x2401. When `dlv_valid_o` is low, code, CPU address and parameter are 0.
- R10: A source event that arrives in the same cycle as a delivery that clears that same source leaves the source pending. For an emergency signal, this holds for the same sender bit.
- R11: After reset, no source is pending and all delivery outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_enable_i | input | 1 | External interrupts enabled in the processor status |
| sc_mask_i | input | 5 | Subclass mask, one bit per source |
| emg_send_i | input | 1 | Emergency signal received |
| emg_src_i | input | 6 | Index of the sending CPU |
| xcall_set_i | input | 1 | External call received |
| xcall_addr_i | input | 16 | Address of the calling CPU |
| ckc_set_i | input | 1 | Clock-comparator condition raised |
| tmr_set_i | input | 1 | CPU-timer condition raised |
| svc_avail_i | input | 1 | Service queue non-empty |
| svc_param_i | input | 32 | Head-of-queue service parameter |
| deliver_i | input | 1 | Delivery strobe |
| any_elig_o | output | 1 | Some source is eligible |
| svc_pop_o | output | 1 | Dequeue the service queue this cycle |
| pend_o | output | 4 | Pending flags: timer, clock comparator, call, emergency (bit 3 down to 0) |
| dlv_valid_o | output | 1 | Delivery result valid |
| dlv_err_o | output | 1 | Strobe could not be honoured |
| dlv_code_o | output | 16 | Interrupt code |
| dlv_cpu_o | output | 16 | Originating CPU address |
| dlv_param_o | output | 32 | Interrupt parameter |

## Verification
The hardest case to reach is an emergency delivery that clears a sender bit in the same cycle as a new signal from that same sender. It matters most when that sender is the last one left, because then the pending flag must not fall. The stimulus first loads several senders at scattered indices, including 0 and 63, and drains them in order. It then repeats a delivery while re-sending from the lowest index. A long random phase then mixes masks, enables and events, so the same-cycle collision also occurs on the other sources.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NSRC    = 5;
  localparam int S_EMG   = 0;
  localparam int S_XCALL = 1;
  localparam int S_CKC   = 2;
  localparam int S_TMR   = 3;
  localparam int S_SVC   = 4;
  localparam int NSTORED = 4;  // sources with local pending state
endpackage

// File: rtl/ext_irq_lsb_enc.sv
module ext_irq_lsb_enc #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  // bit 0 has highest priority
  for (genvar k = 0; k < N; k++) begin : g_pri
    if (k == 0) begin : g_top
      assign grant_o[k] = elig_i[k];
    end else begin : g_low
      assign grant_o[k] = elig_i[k] & ~(|elig_i[k-1:0]);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend
  import ext_irq_pkg::*;
#(
  parameter int N_CPU  = 64,
  parameter int ADDR_W = 16,
  parameter int CPU_AW = $clog2(N_CPU)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               emg_send_i,
  input  logic [CPU_AW-1:0]  emg_src_i,
  input  logic               xcall_set_i,
  input  logic [ADDR_W-1:0]  xcall_addr_i,
  input  logic               ckc_set_i,
  input  logic               tmr_set_i,
  input  logic [NSTORED-1:0] take_i,
  output logic [NSTORED-1:0] pend_o,
  output logic [CPU_AW-1:0]  emg_idx_o,
  output logic [ADDR_W-1:0]  xcall_addr_o
);
  logic [N_CPU-1:0]  map_q, map_clr, map_set, map_left, map_nxt;
  logic              emg_q, xcall_q, ckc_q, tmr_q;
  logic [ADDR_W-1:0] xaddr_q;
  logic              emg_found;

  ext_irq_lsb_enc #(.N(N_CPU), .IW(CPU_AW)) u_enc (
    .vec_i   (map_q),
    .idx_o   (emg_idx_o),
    .found_o (emg_found)
  );

  always_comb begin
    map_clr  = take_i[S_EMG] ? (N_CPU'(1) << emg_idx_o) : '0;
    map_set  = emg_send_i ? (N_CPU'(1) << emg_src_i) : '0;
    map_left = map_q & ~map_clr;
    map_nxt  = map_left | map_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q   <= '0;
      emg_q   <= 1'b0;
      xcall_q <= 1'b0;
      xaddr_q <= '0;
      ckc_q   <= 1'b0;
      tmr_q   <= 1'b0;
    end else begin
      map_q <= map_nxt;
      if (emg_send_i)                          emg_q <= 1'b1;
      else if (take_i[S_EMG] && ~|map_left)    emg_q <= 1'b0;
      if (xcall_set_i) begin
        xcall_q <= 1'b1;
        xaddr_q <= xcall_addr_i;
      end else if (take_i[S_XCALL]) begin
        xcall_q <= 1'b0;
      end
      if (ckc_set_i)               ckc_q <= 1'b1;
      else if (take_i[S_CKC])      ckc_q <= 1'b0;
      if (tmr_set_i)               tmr_q <= 1'b1;
      else if (take_i[S_TMR])      tmr_q <= 1'b0;
    end
  end

  assign pend_o       = {tmr_q, ckc_q, xcall_q, emg_q};
  assign xcall_addr_o = xaddr_q;

  AST_EMG_FLAG_TRACKS_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emg_q == emg_found); // R3
  AST_EMG_BIT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i[S_EMG] && !(emg_send_i && emg_src_i == emg_idx_o)) |=> !map_q[$past(emg_idx_o)]); // R2
  AST_CKC_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckc_set_i |=> ckc_q); // R10
endmodule

// File: rtl/ext_irq_selector.sv
module ext_irq_selector
  import ext_irq_pkg::*;
#(
  parameter int          N_CPU     = 64,
  parameter int          ADDR_W    = 16,
  parameter int          PARAM_W   = 32,
  parameter int          CODE_W    = 16,
  parameter logic [15:0] CODE_EMG   = 16'h1201,
  parameter logic [15:0] CODE_XCALL = 16'h1202,
  parameter logic [15:0] CODE_CKC   = 16'h1004,
  parameter logic [15:0] CODE_TMR   = 16'h1005,
  parameter logic [15:0] CODE_SVC   = 16'h2401
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ext_enable_i,
  input  logic [NSRC-1:0]           sc_mask_i,
  input  logic                      emg_send_i,
  input  logic [$clog2(N_CPU)-1:0]  emg_src_i,
  input  logic                      xcall_set_i,
  input  logic [ADDR_W-1:0]         xcall_addr_i,
  input  logic                      ckc_set_i,
  input  logic                      tmr_set_i,
  input  logic                      svc_avail_i,
  input  logic [PARAM_W-1:0]        svc_param_i,
  input  logic                      deliver_i,
  output logic                      any_elig_o,
  output logic                      svc_pop_o,
  output logic [NSTORED-1:0]        pend_o,
  output logic                      dlv_valid_o,
  output logic                      dlv_err_o,
  output logic [CODE_W-1:0]         dlv_code_o,
  output logic [ADDR_W-1:0]         dlv_cpu_o,
  output logic [PARAM_W-1:0]        dlv_param_o
);
  localparam int CPU_AW = $clog2(N_CPU);

  logic [NSTORED-1:0] pend, take;
  logic [NSRC-1:0]    elig, grant;
  logic               any, fire;
  logic [CPU_AW-1:0]  emg_idx;
  logic [ADDR_W-1:0]  xaddr;
  logic [CODE_W-1:0]  sel_code;
  logic [ADDR_W-1:0]  sel_cpu;
  logic [PARAM_W-1:0] sel_param;

  ext_irq_pend #(.N_CPU(N_CPU), .ADDR_W(ADDR_W), .CPU_AW(CPU_AW)) u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .emg_send_i   (emg_send_i),
    .emg_src_i    (emg_src_i),
    .xcall_set_i  (xcall_set_i),
    .xcall_addr_i (xcall_addr_i),
    .ckc_set_i    (ckc_set_i),
    .tmr_set_i    (tmr_set_i),
    .take_i       (take),
    .pend_o       (pend),
    .emg_idx_o    (emg_idx),
    .xcall_addr_o (xaddr)
  );

  assign elig = {svc_avail_i, pend} & sc_mask_i;

  ext_irq_arb #(.N(NSRC)) u_arb (
    .elig_i  (elig),
    .grant_o (grant),
    .any_o   (any)
  );

  assign fire       = deliver_i & ext_enable_i & any;
  assign take       = fire ? grant[NSTORED-1:0] : '0;
  assign svc_pop_o  = fire & grant[S_SVC];
  assign any_elig_o = any;
  assign pend_o     = pend;

  always_comb begin
    sel_code  = '0;
    sel_cpu   = '0;
    sel_param = '0;
    if (grant[S_EMG]) begin
      sel_code = CODE_W'(CODE_EMG);
      sel_cpu  = ADDR_W'(emg_idx);
    end else if (grant[S_XCALL]) begin
      sel_code = CODE_W'(CODE_XCALL);
      sel_cpu  = xaddr;
    end else if (grant[S_CKC]) begin
      sel_code = CODE_W'(CODE_CKC);
    end else if (grant[S_TMR]) begin
      sel_code = CODE_W'(CODE_TMR);
    end else if (grant[S_SVC]) begin
      sel_code  = CODE_W'(CODE_SVC);
      sel_param = svc_param_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_valid_o <= 1'b0;
      dlv_err_o   <= 1'b0;
      dlv_code_o  <= '0;
      dlv_cpu_o   <= '0;
      dlv_param_o <= '0;
    end else begin
      dlv_valid_o <= fire;
      dlv_err_o   <= deliver_i & ~fire;
      dlv_code_o  <= fire ? sel_code  : '0;
      dlv_cpu_o   <= fire ? sel_cpu   : '0;
      dlv_param_o <= fire ? sel_param : '0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R1
  AST_VALID_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dlv_valid_o && dlv_err_o)); // R8
  AST_POP_GIVES_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_pop_o |=> (dlv_valid_o && dlv_code_o == CODE_W'(CODE_SVC))); // R6
  AST_LOCAL_CPU_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && (dlv_code_o == CODE_W'(CODE_CKC) || dlv_code_o == CODE_W'(CODE_TMR)))
      |-> (dlv_cpu_o == '0 && dlv_param_o == '0)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dlv_valid_o |-> (dlv_code_o == '0 && dlv_cpu_o == '0)); // R9
endmodule

// File: tb/ext_irq_selector_bench.sv
module ext_irq_selector_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, en, emg_send, xcall_set, ckc_set, tmr_set, svc_avail, deliver;
  logic [4:0]  mask;
  logic [5:0]  emg_src;
  logic [15:0] xcall_addr;
  logic [31:0] svc_param;
  logic        any_elig, svc_pop, d_valid, d_err;
  logic [3:0]  pend;
  logic [15:0] d_code, d_cpu;
  logic [31:0] d_param;

  ext_irq_selector u_ext_irq_selector (
    .clk_i(clk), .rst_ni(rst_n), .ext_enable_i(en), .sc_mask_i(mask),
    .emg_send_i(emg_send), .emg_src_i(emg_src), .xcall_set_i(xcall_set),
    .xcall_addr_i(xcall_addr), .ckc_set_i(ckc_set), .tmr_set_i(tmr_set),
    .svc_avail_i(svc_avail), .svc_param_i(svc_param), .deliver_i(deliver),
    .any_elig_o(any_elig), .svc_pop_o(svc_pop), .pend_o(pend),
    .dlv_valid_o(d_valid), .dlv_err_o(d_err), .dlv_code_o(d_code),
    .dlv_cpu_o(d_cpu), .dlv_param_o(d_param)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R11";

  // reference state
  bit          m_map [64];
  bit          m_xc, m_ckc, m_tmr;
  logic [15:0] m_xaddr;
  bit          e_valid, e_err;
  logic [15:0] e_code, e_cpu;
  logic [31:0] e_param;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_emg();
    for (int i = 0; i < 64; i++) if (m_map[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int lowest();
    for (int i = 0; i < 64; i++) if (m_map[i]) return i;
    return -1;
  endfunction

  function automatic int winner();
    bit p [5];
    p[0] = m_emg(); p[1] = m_xc; p[2] = m_ckc; p[3] = m_tmr; p[4] = svc_avail;
    for (int k = 0; k < 5; k++) if (p[k] && mask[k]) return k;
    return -1;
  endfunction

  // one clock: compare combinational outputs, advance model, compare registered outputs
  task automatic cyc();
    int w, lo;
    bit fire;
    #1;
    w    = winner();
    fire = deliver && en && (w >= 0);
    chk("R7", "any_elig", any_elig, w >= 0);
    chk("R6", "svc_pop", svc_pop, fire && w == 4);
    chk(cur_tag, "pend", pend, {m_tmr, m_ckc, m_xc, m_emg()});
    e_valid = fire; e_err = deliver && !fire;
    e_code = 0; e_cpu = 0; e_param = 0;
    if (fire) begin
      case (w)
        0: begin lo = lowest(); e_code = 16'h1201; e_cpu = 16'(lo); m_map[lo] = 1'b0; end
        1: begin e_code = 16'h1202; e_cpu = m_xaddr; m_xc = 1'b0; end
        2: begin e_code = 16'h1004; m_ckc = 1'b0; end
        3: begin e_code = 16'h1005; m_tmr = 1'b0; end
        default: begin e_code = 16'h2401; e_param = svc_param; end
      endcase
    end
    if (emg_send)  m_map[emg_src] = 1'b1;
    if (xcall_set) begin m_xc = 1'b1; m_xaddr = xcall_addr; end
    if (ckc_set)   m_ckc = 1'b1;
    if (tmr_set)   m_tmr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "valid", d_valid, e_valid);
    chk("R8", "err", d_err, e_err);
    chk(cur_tag, "code", d_code, e_code);
    chk(cur_tag, "cpu", d_cpu, e_cpu);
    chk(cur_tag, "param", d_param, e_param);
    deliver = 0; emg_send = 0; xcall_set = 0; ckc_set = 0; tmr_set = 0;
  endtask

  task automatic send(int cpu);
    emg_send = 1; emg_src = 6'(cpu); cyc();
  endtask

  task automatic dlv();
    deliver = 1; cyc();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 0; en = 0; mask = 0; emg_send = 0; emg_src = 0; xcall_set = 0;
    xcall_addr = 0; ckc_set = 0; tmr_set = 0; svc_avail = 0; svc_param = 0; deliver = 0;
    for (int i = 0; i < 64; i++) m_map[i] = 0;
    m_xc = 0; m_ckc = 0; m_tmr = 0; m_xaddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11", "valid", d_valid, 0);
    chk("R11", "pend", pend, 0);
    chk("R11", "code", d_code, 0);
    cyc();

    en = 1; mask = 5'h1f;
    cur_tag = "R8"; dlv();                           // nothing eligible
    cur_tag = "R1"; ckc_set = 1; tmr_set = 1; cyc();
    dlv();                                           // clock comparator first
    cur_tag = "R5"; dlv();                           // then timer
    cur_tag = "R2";
    send(40); send(5); send(63); send(0);
    xcall_set = 1; xcall_addr = 16'h1234; cyc();
    cur_tag = "R3"; dlv(); dlv(); dlv();             // 0,5,40 ; flag still up
    dlv();                                           // 63 ; flag falls
    cur_tag = "R4"; dlv();
    cur_tag = "R1"; send(9); xcall_set = 1; xcall_addr = 16'h00aa; cyc();
    mask = 5'h1e; dlv();                             // call wins with emergency masked
    cur_tag = "R8"; mask = 5'h1f; en = 0; dlv();     // disabled: no change
    en = 1;
    cur_tag = "R10"; deliver = 1; emg_send = 1; emg_src = 9; cyc();  // same bit re-sent
    dlv();
    ckc_set = 1; cyc(); deliver = 1; ckc_set = 1; cyc(); dlv();
    cur_tag = "R4"; xcall_set = 1; xcall_addr = 16'h0001; cyc();
    xcall_set = 1; xcall_addr = 16'h0777; cyc(); dlv();
    cur_tag = "R6"; svc_avail = 1; svc_param = 32'hdeadbeef; dlv();
    tmr_set = 1; cyc(); dlv(); svc_avail = 0;

    cur_tag = "R1";
    for (int n = 0; n < 3000; n++) begin
      mask       = 5'($urandom);
      en         = ($urandom % 8) != 0;
      svc_avail  = $urandom % 2;
      svc_param  = $urandom;
      emg_send   = ($urandom % 3) == 0;
      emg_src    = 6'($urandom);
      xcall_set  = ($urandom % 6) == 0;
      xcall_addr = 16'($urandom);
      ckc_set    = ($urandom % 6) == 0;
      tmr_set    = ($urandom % 6) == 0;
      deliver    = $urandom % 2;
      cyc();
    end
    summary();
  end
endmodule